// File: doc/BRIEF.md
# PC Card DMA Signal Remapper

This block sits between the DMA channel of a host controller and a 16-bit PC Card socket. A 2-bit run-time select field names one of three card status inputs as the card's DMA request line. That line is treated as active low, passed through a synchronizer and presented to the host as an active-high request.

While a real DMA transfer cycle is on the socket, the block changes what three socket strobes mean. The register-select pin is driven high as the card's acknowledge. The output-enable pin or the write-enable pin carries an active-low terminal count, depending on the direction of the transfer. Outside such cycles, every strobe simply follows the value that the normal access logic supplies.

The select field is sampled into an internal register, and that register is only updated at clock edges where no DMA cycle is in progress. This keeps the meaning of the pins fixed for the whole of a transfer.

Top module: `pccard_dma_remap`

## Requirements
- R1: The applied select value chooses the request source: 2'b10 takes `card_iois_n`, 2'b11 takes `card_spkr_n`, and 2'b01 takes `card_inpack_n`. The chosen pin is active low. `host_drq` is high two rising edges after the chosen pin is sampled low, and low two edges after it is sampled high.
- R2: While the applied select is 2'b00, the request into the synchronizer is low. `host_drq` is therefore low from the second edge onward, and the socket strobes never take a DMA meaning.
- R3: A DMA cycle is in progress when the applied select is nonzero, `host_dack` is high, and `io_rd_n` or `io_wr_n` is low. During that cycle `sock_reg_n` is driven high. Otherwise it equals `std_reg_n`.
- R4: In a DMA cycle with `io_rd_n` low (a DMA write), `sock_oe_n` equals the inverse of `host_tc`. Otherwise `sock_oe_n` equals `std_oe_n`.
- R5: In a DMA cycle with `io_wr_n` low (a DMA read), `sock_we_n` equals the inverse of `host_tc`. Otherwise `sock_we_n` equals `std_we_n`.
- R6: When `host_dack` is high but both I/O strobes are high, no acknowledge is given. All three socket strobes keep their standard values.
- R7: At a rising edge, `cfg_dma_sel` is copied into the applied select only if no DMA cycle is in progress at that edge. Otherwise the old value is held.
- R8: After reset, the applied select is 2'b00 and `host_drq` is low. The status pins that are not selected have no effect on `host_drq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dma_sel | input | 2 | Request source select (00 = off) |
| card_iois_n | input | 1 | Card 16-bit I/O status pin |
| card_spkr_n | input | 1 | Card audio/LED status pin |
| card_inpack_n | input | 1 | Card input-acknowledge pin |
| host_dack | input | 1 | Host DMA acknowledge, active high |
| host_tc | input | 1 | Host terminal count, active high |
| io_rd_n | input | 1 | Socket I/O read strobe |
| io_wr_n | input | 1 | Socket I/O write strobe |
| std_reg_n | input | 1 | Normal-cycle register-select value |
| std_oe_n | input | 1 | Normal-cycle output-enable value |
| std_we_n | input | 1 | Normal-cycle write-enable value |
| sock_reg_n | output | 1 | Socket register-select pin drive |
| sock_oe_n | output | 1 | Socket output-enable pin drive |
| sock_we_n | output | 1 | Socket write-enable pin drive |
| host_drq | output | 1 | Synchronized DMA request to the host, active high |

## Verification
A request to change the select field can arrive in the same cycle as an active DMA transfer. When that happens, the select update must wait while the strobe remapping stays under the old encoding. The bench provokes this with random select changes that overlap random acknowledge and strobe activity, and also with a directed case where the field changes in the middle of a write transfer. A reference model updates its own select only at edges where it sees no transfer. Every cycle, the bench compares the model's request timing and strobe drives with the block's outputs.

// File: rtl/pcdma_pkg.sv
package pcdma_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_OFF    = 2'b00,
    SRC_INPACK = 2'b01,
    SRC_IOIS   = 2'b10,
    SRC_SPKR   = 2'b11
  } dma_src_e;
endpackage

// File: rtl/pcdma_sync.sv
module pcdma_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pcdma_req_sel.sv
module pcdma_req_sel
  import pcdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             busy,
  input  logic             iois_n,
  input  logic             spkr_n,
  input  logic             inpack_n,
  output dma_src_e         sel_q,
  output logic             req
);
  dma_src_e sel_d;
  logic     sel_en;

  assign sel_en = !busy;

  always_comb begin
    sel_d = sel_q;
    if (sel_en) sel_d = dma_src_e'(cfg_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SRC_OFF;
    else        sel_q <= sel_d;
  end

  always_comb begin
    unique case (sel_q)
      SRC_IOIS:   req = !iois_n;
      SRC_SPKR:   req = !spkr_n;
      SRC_INPACK: req = !inpack_n;
      default:    req = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcdma_strobe_map.sv
module pcdma_strobe_map
  import pcdma_pkg::*;
(
  input  dma_src_e sel_q,
  input  logic     dack,
  input  logic     tc,
  input  logic     rd_n,
  input  logic     wr_n,
  input  logic     std_reg_n,
  input  logic     std_oe_n,
  input  logic     std_we_n,
  output logic     busy,
  output logic     reg_n,
  output logic     oe_n,
  output logic     we_n
);
  logic dma_wr;
  logic dma_rd;

  assign busy   = (sel_q != SRC_OFF) && dack && (!rd_n || !wr_n);
  assign dma_wr = busy && !rd_n;
  assign dma_rd = busy && !wr_n;

  always_comb begin
    reg_n = busy   ? 1'b1 : std_reg_n;
    oe_n  = dma_wr ? !tc  : std_oe_n;
    we_n  = dma_rd ? !tc  : std_we_n;
  end
endmodule

// File: rtl/pccard_dma_remap.sv
module pccard_dma_remap
  import pcdma_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_dma_sel,
  input  logic             card_iois_n,
  input  logic             card_spkr_n,
  input  logic             card_inpack_n,
  input  logic             host_dack,
  input  logic             host_tc,
  input  logic             io_rd_n,
  input  logic             io_wr_n,
  input  logic             std_reg_n,
  input  logic             std_oe_n,
  input  logic             std_we_n,
  output logic             sock_reg_n,
  output logic             sock_oe_n,
  output logic             sock_we_n,
  output logic             host_drq
);
  logic     rst_ni;
  dma_src_e sel_q;
  logic     busy;
  logic     card_req;

  pcdma_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  pcdma_req_sel u_req_sel (
    .clk(clk), .rst_n(rst_ni), .cfg_sel(cfg_dma_sel), .busy(busy),
    .iois_n(card_iois_n), .spkr_n(card_spkr_n), .inpack_n(card_inpack_n),
    .sel_q(sel_q), .req(card_req)
  );

  pcdma_strobe_map u_map (
    .sel_q(sel_q), .dack(host_dack), .tc(host_tc),
    .rd_n(io_rd_n), .wr_n(io_wr_n),
    .std_reg_n(std_reg_n), .std_oe_n(std_oe_n), .std_we_n(std_we_n),
    .busy(busy), .reg_n(sock_reg_n), .oe_n(sock_oe_n), .we_n(sock_we_n)
  );

  pcdma_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_ni), .d(card_req), .q(host_drq)
  );
endmodule

// File: rtl/pcdma_chk.sv
module pcdma_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic [1:0] sel_q,
  input logic       card_req,
  input logic       host_dack,
  input logic       host_tc,
  input logic       io_rd_n,
  input logic       io_wr_n,
  input logic       std_reg_n,
  input logic       sock_reg_n,
  input logic       sock_oe_n,
  input logic       sock_we_n,
  input logic       host_drq
);
  logic [1:0] age_q;
  logic       req_d1_q;
  logic       req_d2_q;
  logic       xfer;

  assign xfer = (sel_q != 2'b00) && host_dack && (!io_rd_n || !io_wr_n);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q    <= '0;
      req_d1_q <= 1'b0;
      req_d2_q <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      req_d1_q <= card_req;
      req_d2_q <= req_d1_q;
    end
  end

  // R1
  drq_latency_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (host_drq == req_d2_q));

  // R3
  reg_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer |-> sock_reg_n);

  // R6
  reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_rd_n && io_wr_n) |-> (sock_reg_n == std_reg_n));

  // R4
  oe_tc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer && !io_rd_n) |-> (sock_oe_n == !host_tc));

  // R5
  we_tc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer && !io_wr_n) |-> (sock_we_n == !host_tc));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer |=> $stable(sel_q));
endmodule

bind pccard_dma_remap pcdma_chk chk_i (
  .clk(clk), .rst_ni(rst_ni), .sel_q(sel_q), .card_req(card_req),
  .host_dack(host_dack), .host_tc(host_tc), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
  .std_reg_n(std_reg_n), .sock_reg_n(sock_reg_n), .sock_oe_n(sock_oe_n),
  .sock_we_n(sock_we_n), .host_drq(host_drq)
);

// File: tb/pccard_dma_remap_tb.sv
module pccard_dma_remap_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_dma_sel = 2'b00;
  logic card_iois_n = 1'b1, card_spkr_n = 1'b1, card_inpack_n = 1'b1;
  logic host_dack = 1'b0, host_tc = 1'b0, io_rd_n = 1'b1, io_wr_n = 1'b1;
  logic std_reg_n = 1'b1, std_oe_n = 1'b1, std_we_n = 1'b1;
  logic sock_reg_n, sock_oe_n, sock_we_n, host_drq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] m_sel = 2'b00;
  logic m_s1 = 1'b0, m_s2 = 1'b0;

  always #4 clk = !clk;

  pccard_dma_remap dut_i (.*);

  function automatic logic f_req(input logic [1:0] s, input logic a, input logic b, input logic c);
    case (s)
      2'b10:   return !a;
      2'b11:   return !b;
      2'b01:   return !c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic f_busy(input logic [1:0] s);
    return (s != 2'b00) && host_dack && (!io_rd_n || !io_wr_n);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_s2 = m_s1;
      m_s1 = f_req(m_sel, card_iois_n, card_spkr_n, card_inpack_n);
      if (!f_busy(m_sel)) m_sel = cfg_dma_sel;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_pins(input string tag);
    logic b, er, eo, ew;
    b  = f_busy(m_sel);
    er = b ? 1'b1 : std_reg_n;
    eo = (b && !io_rd_n) ? !host_tc : std_oe_n;
    ew = (b && !io_wr_n) ? !host_tc : std_we_n;
    chk({tag, " R3 reg"}, sock_reg_n, er);
    chk({tag, " R4 oe"},  sock_oe_n,  eo);
    chk({tag, " R5 we"},  sock_we_n,  ew);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 drq after reset", host_drq, 1'b0);
    host_dack = 1'b1; io_rd_n = 1'b0; host_tc = 1'b1; std_oe_n = 1'b0; #1;
    chk("R2 oe off", sock_oe_n, 1'b0);
    chk("R2 reg off", sock_reg_n, std_reg_n);
    host_dack = 1'b0; io_rd_n = 1'b1; std_oe_n = 1'b1;

    // R1 directed per encoding, R8 unselected pins ignored
    for (int e = 1; e < 4; e++) begin
      @(negedge clk); cfg_dma_sel = 2'(e);
      @(negedge clk); @(negedge clk);
      card_iois_n = (e != 2); card_spkr_n = (e != 3); card_inpack_n = (e != 1);
      @(negedge clk); chk("R1 drq one edge", host_drq, 1'b0);
      @(negedge clk); chk("R1 drq two edges", host_drq, 1'b1);
      card_iois_n = (e == 2); card_spkr_n = (e == 3); card_inpack_n = (e == 1);
      repeat (3) @(negedge clk);
      chk("R8 unselected ignored", host_drq, 1'b0);
      card_iois_n = 1'b1; card_spkr_n = 1'b1; card_inpack_n = 1'b1;
    end

    // R6 dack without strobes
    @(negedge clk); host_dack = 1'b1; std_reg_n = 1'b0; std_we_n = 1'b0; #1;
    chk("R6 reg", sock_reg_n, 1'b0);
    chk("R6 we", sock_we_n, 1'b0);
    host_dack = 1'b0; std_reg_n = 1'b1; std_we_n = 1'b1;

    // R7 select change during a write transfer is held
    @(negedge clk); cfg_dma_sel = 2'b10;
    @(negedge clk); host_dack = 1'b1; io_rd_n = 1'b0; host_tc = 1'b0; cfg_dma_sel = 2'b00;
    @(negedge clk); @(negedge clk); #1;
    chk("R7 held reg", sock_reg_n, 1'b1);
    chk("R7 held oe", sock_oe_n, 1'b1);
    host_tc = 1'b1; #1;
    chk("R4 tc low", sock_oe_n, 1'b0);
    host_dack = 1'b0; io_rd_n = 1'b1;
    @(negedge clk); @(negedge clk);
    host_dack = 1'b1; io_wr_n = 1'b0; #1;
    chk("R7 applied off", sock_reg_n, std_reg_n);
    host_dack = 1'b0; io_wr_n = 1'b1; host_tc = 1'b0;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chk("R1 R2 drq model", host_drq, m_s2);
      if ($urandom_range(0, 15) == 0) cfg_dma_sel = 2'($urandom);
      card_iois_n   = 1'($urandom);
      card_spkr_n   = 1'($urandom);
      card_inpack_n = 1'($urandom);
      host_dack = 1'($urandom);
      host_tc   = 1'($urandom);
      io_rd_n   = ($urandom_range(0, 2) != 0);
      io_wr_n   = ($urandom_range(0, 2) != 0);
      std_reg_n = 1'($urandom);
      std_oe_n  = 1'($urandom);
      std_we_n  = 1'($urandom);
      #1;
      chk_pins("rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule